// File: doc/BRIEF.md
# Video Crop Window Line Buffer

This block takes a parallel RGB video stream (pixel clock, data enable, vertical sync, 24-bit pixels) and keeps a fixed rectangular window of it. The window's left and top edges and its width are parameters; its height is one line per output channel, sixteen by default. Position counters on the write side locate each incoming pixel, and only pixels that fall inside the window are stored, at window-relative coordinates.

Storage is split into two banks. One bank receives video while the other is offered for random read access in a second clock domain. When a whole window has been written and the next vertical sync begins, the write bank flips. The index of the finished bank crosses to the read domain beside a synchronized toggle. The reader adopts the newest finished bank only at its own frame-start strobe, so an output frame never mixes two images. The write side accepts one pixel per pixel clock with no stall, which is enough for 60 frames per second at any pixel rate the memory can run at.

Top module: `crop_window_buffer`

## Requirements
- R1: The column count is 0 on the first pixel of every data-enable pulse and rises by one per enabled pixel. The row count rises by one when data enable falls, and it is held at 0 while vertical sync is high.
- R2: A pixel is stored only when its column lies in [WIN_X, WIN_X+WIN_LEN) and its row in [WIN_Y, WIN_Y+WIN_ROWS). Source pixel (row, col) is read back at rdRow = row-WIN_Y, rdCol = col-WIN_X.
- R3: The write bank flips on the rising edge of vertical sync only if the last window row has been written since the previous rising edge. Otherwise the bank is kept, and the half-written frame is never offered to the reader.
- R4: Each flip toggles a ready flag that reaches the read domain through two synchronizing flops. A flip at pixel edge k cannot change rdBank before read edge k+3, counted in a common clock.
- R5: rdBank changes only on a read clock edge where rdFrameStart is high. A completion that arrives between strobes is held until the next strobe.
- R6: At a strobe, the reader takes the bank most recently completed, even if other completions came before it.
- R7: A completion whose synchronized edge is seen in the same read cycle as rdFrameStart is applied by that strobe.
- R8: rdPixel shows the pixel at {rdBank, rdRow, rdCol} one read clock after the address is presented.
- R9: After reset, rdBank is 0 and rdFrameValid is 0. rdFrameValid goes to 1 at the first applied swap and stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pixClk | input | 1 | Video pixel clock |
| pixRstN | input | 1 | Active-low reset, pixel domain |
| vidDe | input | 1 | Data enable, high on active pixels |
| vidVs | input | 1 | Vertical sync, active high |
| vidRgb | input | 24 | Pixel data, 8 bits per colour |
| rdClk | input | 1 | Read-side clock |
| rdRstN | input | 1 | Active-low reset, read domain |
| rdFrameStart | input | 1 | Reader frame-start strobe, one read cycle |
| rdRow | input | ROW_W | Window row to read |
| rdCol | input | COL_W | Window column to read |
| rdPixel | output | 24 | Registered read data |
| rdBank | output | 1 | Bank currently offered to the reader |
| rdFrameValid | output | 1 | High once any completed frame has been offered |

## Verification
The two events that can coincide are the arrival of a synchronized completion edge in the read domain and the reader's frame-start strobe. The bench drives both clocks from one source, so the completion edge has a fixed arrival cycle. It raises the strobe for exactly that cycle, three edges after the sync edge that caused the flip. It then checks that rdBank is unchanged one cycle earlier and has moved right after the strobe. Every window pixel is then read back to confirm that the new image, and not the old one, is offered.

// File: rtl/crop_pkg.sv
package crop_pkg;
  // Strobes from the write-side control to the datapath
  typedef struct packed {
    logic wrEn;      // store the current pixel
    logic wrBank;    // bank that receives writes
    logic readyTgl;  // flips once per completed window
    logic doneBank;  // bank finished at the last flip
  } cropStrobes_t;
endpackage

// File: rtl/crop_ctrl.sv
module crop_ctrl #(
  parameter int WIN_X       = 8,
  parameter int WIN_Y       = 2,
  parameter int WIN_LEN     = 48,
  parameter int WIN_ROWS    = 16,
  parameter int LINE_STRIDE = 64,
  parameter int CNT_W       = 12,
  localparam int COL_W = $clog2(LINE_STRIDE),
  localparam int ROW_W = $clog2(WIN_ROWS)
) (
  input  logic                      pixClk,
  input  logic                      pixRstN,
  input  logic                      vidDe,
  input  logic                      vidVs,
  output crop_pkg::cropStrobes_t    st,
  output logic [ROW_W-1:0]          wrRow,
  output logic [COL_W-1:0]          wrCol
);
  localparam logic [CNT_W-1:0] X_LO     = CNT_W'(WIN_X);
  localparam logic [CNT_W-1:0] X_HI     = CNT_W'(WIN_X + WIN_LEN);
  localparam logic [CNT_W-1:0] Y_LO     = CNT_W'(WIN_Y);
  localparam logic [CNT_W-1:0] Y_HI     = CNT_W'(WIN_Y + WIN_ROWS);
  localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(WIN_Y + WIN_ROWS - 1);

  logic             deD, vsD;
  logic [CNT_W-1:0] colCnt, rowCnt, curCol;
  logic             deRise, deFall, vsRise;
  logic             winDone, wrBank, readyTgl, doneBank;
  logic             colIn, rowIn;

  assign deRise = vidDe & ~deD;
  assign deFall = ~vidDe & deD;
  assign vsRise = vidVs & ~vsD;
  assign curCol = deRise ? '0 : colCnt;

  // Window test on the current pixel position
  assign colIn = (curCol >= X_LO) && (curCol < X_HI);
  assign rowIn = (rowCnt >= Y_LO) && (rowCnt < Y_HI);

  always_comb begin
    st.wrEn     = vidDe & colIn & rowIn;
    st.wrBank   = wrBank;
    st.readyTgl = readyTgl;
    st.doneBank = doneBank;
    wrCol       = COL_W'(curCol - X_LO);
    wrRow       = ROW_W'(rowCnt - Y_LO);
  end

  always_ff @(posedge pixClk or negedge pixRstN) begin
    if (!pixRstN) begin
      deD      <= 1'b0;
      vsD      <= 1'b0;
      colCnt   <= '0;
      rowCnt   <= '0;
      winDone  <= 1'b0;
      wrBank   <= 1'b0;
      readyTgl <= 1'b0;
      doneBank <= 1'b0;
    end else begin
      deD <= vidDe;
      vsD <= vidVs;
      if (vidDe) colCnt <= curCol + 1'b1;
      if (vidVs)       rowCnt <= '0;
      else if (deFall) rowCnt <= rowCnt + 1'b1;
      if (deFall && rowCnt == LAST_ROW) winDone <= 1'b1;
      if (vsRise) begin
        winDone <= 1'b0;
        if (winDone) begin
          wrBank   <= ~wrBank;
          readyTgl <= ~readyTgl;
          doneBank <= wrBank;
        end
      end
    end
  end

  assert_col_restart_R1: assert property (@(posedge pixClk) disable iff (!pixRstN)
    $rose(vidDe) |=> colCnt == CNT_W'(1));
  assert_row_clear_R1: assert property (@(posedge pixClk) disable iff (!pixRstN)
    vidVs |=> rowCnt == '0);
  assert_flip_at_vs_R3: assert property (@(posedge pixClk) disable iff (!pixRstN)
    (wrBank != $past(wrBank)) |-> ($past(vidVs) && !$past(vsD)));
  assert_no_flip_partial_R3: assert property (@(posedge pixClk) disable iff (!pixRstN)
    (vsRise && !winDone) |=> wrBank == $past(wrBank));
  assert_toggle_with_flip_R4: assert property (@(posedge pixClk) disable iff (!pixRstN)
    (readyTgl != $past(readyTgl)) |-> (wrBank != $past(wrBank)));
endmodule

// File: rtl/crop_datapath.sv
module crop_datapath #(
  parameter int WIN_ROWS    = 16,
  parameter int LINE_STRIDE = 64,
  parameter int PIX_W       = 24,
  localparam int COL_W = $clog2(LINE_STRIDE),
  localparam int ROW_W = $clog2(WIN_ROWS),
  localparam int ADR_W = 1 + ROW_W + COL_W,
  localparam int DEPTH = 1 << ADR_W
) (
  input  logic                   pixClk,
  input  crop_pkg::cropStrobes_t st,
  input  logic [ROW_W-1:0]       wrRow,
  input  logic [COL_W-1:0]       wrCol,
  input  logic [PIX_W-1:0]       wrData,
  input  logic                   rdClk,
  input  logic                   rdRstN,
  input  logic                   rdFrameStart,
  input  logic [ROW_W-1:0]       rdRow,
  input  logic [COL_W-1:0]       rdCol,
  output logic [PIX_W-1:0]       rdPixel,
  output logic                   rdBank,
  output logic                   rdFrameValid
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge pixClk) begin
    if (st.wrEn) mem[{st.wrBank, wrRow, wrCol}] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    rdPixel <= mem[{rdBank, rdRow, rdCol}];
  end

  // Read-domain handoff: toggle synchronizer and held swap request
  logic syncA, syncB, syncC, tglEdge;
  logic pending, pendBank, takeSwap, newBank;

  assign tglEdge  = syncB ^ syncC;
  assign takeSwap = rdFrameStart & (pending | tglEdge);
  assign newBank  = tglEdge ? st.doneBank : pendBank;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      syncA        <= 1'b0;
      syncB        <= 1'b0;
      syncC        <= 1'b0;
      pending      <= 1'b0;
      pendBank     <= 1'b0;
      rdBank       <= 1'b0;
      rdFrameValid <= 1'b0;
    end else begin
      syncA <= st.readyTgl;
      syncB <= syncA;
      syncC <= syncB;
      if (takeSwap) begin
        rdBank       <= newBank;
        rdFrameValid <= 1'b1;
        pending      <= 1'b0;
      end else if (tglEdge) begin
        pending  <= 1'b1;
        pendBank <= st.doneBank;
      end
    end
  end

  assert_bank_on_strobe_R5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdBank != $past(rdBank)) |-> $past(rdFrameStart));
  assert_pending_cleared_R5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdFrameStart && pending) |=> !pending);
  assert_edge_taken_R7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdFrameStart && tglEdge) |=> (rdFrameValid && !pending));
  assert_valid_sticky_R9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdFrameValid |=> rdFrameValid);
endmodule

// File: rtl/crop_window_buffer.sv
module crop_window_buffer #(
  parameter int WIN_X       = 8,
  parameter int WIN_Y       = 2,
  parameter int WIN_LEN     = 48,
  parameter int WIN_ROWS    = 16,
  parameter int LINE_STRIDE = 64,
  parameter int CNT_W       = 12,
  parameter int PIX_W       = 24,
  localparam int COL_W = $clog2(LINE_STRIDE),
  localparam int ROW_W = $clog2(WIN_ROWS)
) (
  input  logic             pixClk,
  input  logic             pixRstN,
  input  logic             vidDe,
  input  logic             vidVs,
  input  logic [PIX_W-1:0] vidRgb,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdFrameStart,
  input  logic [ROW_W-1:0] rdRow,
  input  logic [COL_W-1:0] rdCol,
  output logic [PIX_W-1:0] rdPixel,
  output logic             rdBank,
  output logic             rdFrameValid
);
  crop_pkg::cropStrobes_t st;
  logic [ROW_W-1:0] wrRow;
  logic [COL_W-1:0] wrCol;

  crop_ctrl #(
    .WIN_X(WIN_X), .WIN_Y(WIN_Y), .WIN_LEN(WIN_LEN), .WIN_ROWS(WIN_ROWS),
    .LINE_STRIDE(LINE_STRIDE), .CNT_W(CNT_W)
  ) ctrl (
    .pixClk(pixClk), .pixRstN(pixRstN), .vidDe(vidDe), .vidVs(vidVs),
    .st(st), .wrRow(wrRow), .wrCol(wrCol)
  );

  crop_datapath #(
    .WIN_ROWS(WIN_ROWS), .LINE_STRIDE(LINE_STRIDE), .PIX_W(PIX_W)
  ) dp (
    .pixClk(pixClk), .st(st), .wrRow(wrRow), .wrCol(wrCol), .wrData(vidRgb),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdFrameStart(rdFrameStart),
    .rdRow(rdRow), .rdCol(rdCol), .rdPixel(rdPixel), .rdBank(rdBank),
    .rdFrameValid(rdFrameValid)
  );
endmodule

// File: tb/crop_window_buffer_test.sv
module crop_window_buffer_test;
  localparam int PERIOD = 10;
  localparam int WX = 5, WY = 3, WL = 24, WR = 16, STRIDE = 32;
  localparam int H_ACT = 40, V_ACT = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vidDe = 1'b0, vidVs = 1'b0;
  logic [23:0] vidRgb = '0;
  logic rdFrameStart = 1'b0;
  logic [3:0] rdRow = '0;
  logic [4:0] rdCol = '0;
  logic [23:0] rdPixel;
  logic rdBank, rdFrameValid;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  crop_window_buffer #(
    .WIN_X(WX), .WIN_Y(WY), .WIN_LEN(WL), .WIN_ROWS(WR), .LINE_STRIDE(STRIDE)
  ) uut (
    .pixClk(clk), .pixRstN(rstN), .vidDe(vidDe), .vidVs(vidVs), .vidRgb(vidRgb),
    .rdClk(clk), .rdRstN(rstN), .rdFrameStart(rdFrameStart),
    .rdRow(rdRow), .rdCol(rdCol), .rdPixel(rdPixel), .rdBank(rdBank),
    .rdFrameValid(rdFrameValid)
  );

  // {tag, lines, strobe, expected tag, expected bank}
  localparam logic [25:0] VECS [5] = '{
    {8'h11, 8'd24, 1'b1, 8'h11, 1'b0},
    {8'h22, 8'd24, 1'b0, 8'h11, 1'b0},
    {8'h33, 8'd24, 1'b1, 8'h33, 1'b0},
    {8'h44, 8'd24, 1'b1, 8'h44, 1'b1},
    {8'h55, 8'd10, 1'b1, 8'h44, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendLines(input logic [7:0] tag, input int nLines);
    for (int l = 0; l < nLines; l++) begin
      for (int c = 0; c < H_ACT; c++) begin
        @(negedge clk);
        vidDe = 1'b1;
        vidRgb = {tag, 8'(l), 8'(c)};
      end
      repeat (6) begin @(negedge clk); vidDe = 1'b0; vidRgb = '0; end
    end
  endtask

  task automatic vsPulse();
    @(negedge clk); vidVs = 1'b1;
    repeat (3) @(negedge clk);
    vidVs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); rdFrameStart = 1'b1;
    @(negedge clk); rdFrameStart = 1'b0;
  endtask

  // R1, R2, R8: every window pixel holds its source coordinates
  task automatic readWin(input logic [7:0] tag, input string req);
    int errs = 0;
    for (int r = 0; r < WR; r++) begin
      for (int c = 0; c < WL; c++) begin
        logic [23:0] exp;
        @(negedge clk); rdRow = 4'(r); rdCol = 5'(c);
        @(negedge clk);
        exp = {tag, 8'(WY + r), 8'(WX + c)};
        if (rdPixel !== exp && errs < 4) begin
          errs++;
          check(1'b0, req, rdPixel, exp);
        end else if (rdPixel === exp) total++;
      end
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rdFrameValid === 1'b0, "R9 reset valid", rdFrameValid, 0);
    check(rdBank === 1'b0, "R9 reset bank", rdBank, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VECS[i]) begin
      logic [7:0] tag, expTag;
      int nl;
      tag = VECS[i][25:18]; nl = int'(VECS[i][17:10]); expTag = VECS[i][8:1];
      sendLines(tag, nl);
      vsPulse();
      check(rdBank === (i == 0 ? 1'b0 : VECS[i-1][0]), "R5 bank held before strobe", rdBank,
            i == 0 ? 0 : VECS[i-1][0]);
      if (VECS[i][9]) strobe();
      repeat (2) @(negedge clk);
      check(rdBank === VECS[i][0], "R3 R5 R6 bank after frame", rdBank, VECS[i][0]);
      check(rdFrameValid === 1'b1, "R9 valid after first swap", rdFrameValid, 1);
      readWin(expTag, "R1 R2 R6 R8 pixel");
    end

    // R4, R7: completion edge and frame-start in one read cycle
    sendLines(8'h66, V_ACT);
    @(negedge clk); vidVs = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(rdBank === 1'b1, "R4 no swap before sync delay", rdBank, 1);
    rdFrameStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdFrameStart = 1'b0;
    check(rdBank === 1'b0, "R7 same-cycle swap", rdBank, 0);
    vidVs = 1'b0;
    repeat (10) @(negedge clk);
    check(rdBank === 1'b0, "R5 bank stable without strobe", rdBank, 0);
    readWin(8'h66, "R7 pixel");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule